// File: doc/BRIEF.md
# Zero-Suppressed Channel Readout Sparsifier

This block streams the converted codes of a bank of channels onto a byte-wide parallel bus and leaves out every channel that has no hit. A pulse on `start_i` captures the per-channel hit flags. The block then walks the channels from the lowest index to the highest. Each hit channel goes out as two consecutive bus words: first its address, then its code. `valid_o` marks both words.

Empty channels are dropped while the readout runs. There is no compaction pass before the first word. A short priority search over a window of channels just ahead of the current position keeps the words back-to-back. When the next hit lies beyond that window, a full-width search moves the position straight to it, and this costs exactly one idle bus cycle. The codes on `code_i` must stay stable while `busy_o` is high. The hit flags need not, because they are captured at the start.

Top module: `zs_readout`

## Requirements
- R1: After reset, `valid_o`, `done_o` and `busy_o` are low and `data_o` is zero.
- R2: Each hit channel produces two words with `valid_o` high. The first is the channel address, with the index in bits 6:0 and bit 7 zero. The second is that channel's 8-bit code, taken from `code_i[8*ch +: 8]`.
- R3: Only hit channels are emitted, each exactly once, in strictly ascending channel order.
- R4: If no hit flag is set at the start, `done_o` rises in the second cycle after `start_i` is sampled, and no valid word appears.
- R5: `done_o` is high for exactly one cycle. That cycle comes straight after the last data word. `busy_o` and `valid_o` are low in that cycle.
- R6: A hit is emitted with no idle cycle before its address word if it lies within WIN channels (default 8) after the previous emitted channel. For the first hit, the same holds if its index is below WIN.
- R7: A hit farther away than that costs exactly one idle cycle (`valid_o` low while busy). The only other idle cycle in a readout is the single cycle between `start_i` being sampled and the first word.
- R8: `start_i` has no effect while `busy_o` is high.
- R9: `hit_i` is sampled only at the start. Changes to it during a readout do not alter the emitted words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Readout clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a readout when idle |
| hit_i | input | NUM_CH | Per-channel hit flags, sampled at start |
| code_i | input | NUM_CH*CODE_W | Per-channel codes, channel c at bits [CODE_W*c +: CODE_W] |
| data_o | output | CODE_W | Bus word: address or code |
| valid_o | output | 1 | Bus word valid |
| busy_o | output | 1 | Readout in progress |
| done_o | output | 1 | One-cycle end-of-readout pulse |

## Verification
The assertions check on every cycle that:
- address words have a clear top bit;
- addresses strictly increase within a readout;
- the captured hit mask only ever loses bits while busy;
- the done pulse lasts one cycle and never overlaps a valid word;
- every idle cycle caused by an empty window is followed by a successful window hit.

Only the bench scenarios can show three further things. First, that the words carry the correct codes. Second, that the idle-cycle count matches the gap pattern of the hits: all channels hit, both end channels hit, gaps exactly at and just past the window size, no hits at all. Third, that start pulses and hit-flag changes during a readout leave the output stream unchanged.

// File: rtl/zs_readout_pkg.sv
`timescale 1ns/1ps
package zs_readout_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_DATA = 2'd2
  } zs_state_e;
endpackage

// File: rtl/zs_prio_enc.sv
`timescale 1ns/1ps
module zs_prio_enc #(
  parameter int unsigned W  = 8,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/zs_window.sv
`timescale 1ns/1ps
module zs_window #(
  parameter int unsigned NUM_CH = 128,
  parameter int unsigned WIN    = 8,
  parameter int unsigned PTR_W  = 8
) (
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [PTR_W-1:0]  base_i,
  output logic [WIN-1:0]    win_o
);
  localparam int unsigned SUM_W = PTR_W + 1;
  localparam int unsigned AW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  for (genvar k = 0; k < WIN; k++) begin : g_tap
    logic [SUM_W-1:0] idx;
    assign idx      = SUM_W'(base_i) + SUM_W'(k);
    // taps past the last channel read as empty
    assign win_o[k] = (idx < SUM_W'(NUM_CH)) ? pend_i[idx[AW-1:0]] : 1'b0;
  end
endmodule

// File: rtl/zs_readout.sv
`timescale 1ns/1ps
module zs_readout
  import zs_readout_pkg::*;
#(
  parameter int unsigned NUM_CH = 128,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned WIN    = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [NUM_CH-1:0]        hit_i,
  input  logic [NUM_CH*CODE_W-1:0] code_i,
  output logic [CODE_W-1:0]        data_o,
  output logic                     valid_o,
  output logic                     busy_o,
  output logic                     done_o
);
  localparam int unsigned ADDR_W = $clog2(NUM_CH);
  localparam int unsigned PTR_W  = ADDR_W + 1;
  localparam int unsigned WIN_IW = (WIN > 1) ? $clog2(WIN) : 1;

  zs_state_e           state_q;
  logic [NUM_CH-1:0]   pend_q;
  logic [PTR_W-1:0]    ptr_q;
  logic [ADDR_W-1:0]   cur_q;
  logic [CODE_W-1:0]   data_q;
  logic                valid_q, done_q;

  logic [CODE_W-1:0]   code_arr [NUM_CH];
  logic [WIN-1:0]      win_bits;
  logic                win_found, any_found;
  logic [WIN_IW-1:0]   win_idx;
  logic [ADDR_W-1:0]   first_idx;
  logic [PTR_W-1:0]    win_ch;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_code
    assign code_arr[c] = code_i[c*CODE_W +: CODE_W];
  end

  zs_window #(.NUM_CH(NUM_CH), .WIN(WIN), .PTR_W(PTR_W)) i_window (
    .pend_i (pend_q),
    .base_i (ptr_q),
    .win_o  (win_bits)
  );

  zs_prio_enc #(.W(WIN)) i_win_enc (
    .req_i   (win_bits),
    .found_o (win_found),
    .idx_o   (win_idx)
  );

  // full-width search, used only to retarget after an empty window
  zs_prio_enc #(.W(NUM_CH)) i_full_enc (
    .req_i   (pend_q),
    .found_o (any_found),
    .idx_o   (first_idx)
  );

  assign win_ch = ptr_q + PTR_W'(win_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      ptr_q   <= '0;
      cur_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            pend_q  <= hit_i;
            ptr_q   <= '0;
            state_q <= ST_SEEK;
          end
        end
        ST_SEEK: begin
          if (!any_found) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (win_found) begin
            data_q  <= CODE_W'(win_ch[ADDR_W-1:0]);
            valid_q <= 1'b1;
            cur_q   <= win_ch[ADDR_W-1:0];
            pend_q[win_ch[ADDR_W-1:0]] <= 1'b0;
            state_q <= ST_DATA;
          end else begin
            ptr_q <= PTR_W'(first_idx);  // one idle cycle
          end
        end
        ST_DATA: begin
          data_q  <= code_arr[cur_q];
          valid_q <= 1'b1;
          ptr_q   <= PTR_W'(cur_q) + PTR_W'(1);
          state_q <= ST_SEEK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign done_o  = done_q;
  assign busy_o  = (state_q != ST_IDLE);

  // checker state: last address put on the bus in this readout
  logic [ADDR_W-1:0] prev_ch_q;
  logic              prev_vld_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ch_q  <= '0;
      prev_vld_q <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      prev_vld_q <= 1'b0;
    end else if (state_q == ST_DATA) begin
      prev_ch_q  <= data_o[ADDR_W-1:0];
      prev_vld_q <= 1'b1;
    end
  end

  // R2
  addr_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (valid_o && data_o[CODE_W-1] == 1'b0));
  // R3
  ascending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && prev_vld_q) |-> (data_o[ADDR_W-1:0] > prev_ch_q));
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!valid_o && !busy_o));
  // R9
  pend_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> ((pend_q & ~$past(pend_q)) == '0));
  // R7
  retarget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEEK && !win_found && any_found) |=> (state_q == ST_SEEK && win_found));
endmodule

// File: tb/test_zs_readout.sv
`timescale 1ns/1ps
module test_zs_readout;
  localparam int NUM_CH = 128;
  localparam int CODE_W = 8;
  localparam int WIN    = 8;

  logic                     clk_i = 1'b0;
  logic                     rst_ni = 1'b0;
  logic                     start_i = 1'b0;
  logic [NUM_CH-1:0]        hit_i = '0;
  logic [NUM_CH*CODE_W-1:0] code_i = '0;
  logic [CODE_W-1:0]        data_o;
  logic                     valid_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  zs_readout #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .WIN(WIN)) i_zs_readout (
    .clk_i, .rst_ni, .start_i, .hit_i, .code_i, .data_o, .valid_o, .busy_o, .done_o
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one readout: R2/R3 words, R5 done pulse, R6/R7 idle count; poke covers R8/R9
  task automatic run_readout(input string name, input logic [NUM_CH-1:0] h,
                             input int seed, input bit poke);
    int exp_w[256];
    int got_w[256];
    int n_exp = 0, n_got = 0, idles = 0, invalid = 0, prev = -1, cyc = 0;
    bit finished = 0;
    for (int c = 0; c < NUM_CH; c++) code_i[c*CODE_W +: CODE_W] = 8'((c * 29 + seed) & 255);
    for (int c = 0; c < NUM_CH; c++) begin
      if (h[c]) begin
        if (c - (prev + 1) >= WIN) idles++;
        exp_w[n_exp++] = c;
        exp_w[n_exp++] = (c * 29 + seed) & 255;
        prev = c;
      end
    end
    @(negedge clk_i);
    hit_i = h;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!finished && cyc < 600) begin
      if (poke && cyc == 4) begin start_i = 1'b1; hit_i = ~h; end
      if (poke && cyc == 5) start_i = 1'b0;
      if (done_o) finished = 1;
      else if (valid_o) begin
        if (n_got < 256) got_w[n_got] = int'(data_o);
        n_got++;
      end else invalid++;
      if (!finished) @(negedge clk_i);
      cyc++;
    end
    check({name, " R5 done reached"}, finished, cyc, 0);
    check({name, " R5 busy low at done"}, !busy_o, busy_o, 0);
    check({name, " R2/R3 word count"}, n_got == n_exp, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check({name, (i % 2 == 0) ? " R2 address word" : " R2 code word"},
            got_w[i] == exp_w[i], got_w[i], exp_w[i]);
    end
    check({name, " R6/R7 idle cycles"}, invalid == 1 + idles, invalid, 1 + idles);
    @(negedge clk_i);
    check({name, " R5 done single cycle"}, !done_o, done_o, 0);
    check({name, " R8 idle after readout"}, !busy_o, busy_o, 0);
    hit_i = '0;
  endtask

  task automatic t_reset();
    check("R1 valid at reset", !valid_o, valid_o, 0);
    check("R1 done at reset", !done_o, done_o, 0);
    check("R1 busy at reset", !busy_o, busy_o, 0);
    check("R1 data at reset", data_o == '0, data_o, 0);
  endtask

  task automatic t_none();
    // R4: done in second cycle after start sampled
    run_readout("no_hits R4", '0, 3, 0);
  endtask

  task automatic t_patterns();
    logic [NUM_CH-1:0] h;
    h = '0; h[0] = 1'b1;
    run_readout("single_ch0", h, 11, 0);
    run_readout("all_hit R6", '1, 5, 0);
    h = '0; h[0] = 1'b1; h[NUM_CH-1] = 1'b1;
    run_readout("both_ends R7", h, 77, 0);
    h = '0; h[NUM_CH-1] = 1'b1;
    run_readout("last_only R7", h, 200, 0);
    // gaps 7 (window edge, no idle) then 8 (one idle)
    h = '0; h[7] = 1'b1; h[15] = 1'b1; h[24] = 1'b1; h[WIN] = 1'b1;
    run_readout("gap_boundary R6 R7", h, 41, 0);
    h = '0;
    for (int c = 3; c < NUM_CH; c += 20) h[c] = 1'b1;
    run_readout("sparse R3", h, 99, 0);
  endtask

  task automatic t_poke();
    logic [NUM_CH-1:0] h;
    h = '0;
    for (int c = 0; c < NUM_CH; c += 9) h[c] = 1'b1;
    run_readout("start_and_hits_during R8 R9", h, 123, 1);
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_none();
    t_patterns();
    t_poke();
    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule